// File: doc/BRIEF.md
# Indirect PHY Register Access Bridge

This block sits on a 16-bit host register bus and gives the host a path to the internal registers of up to five embedded PHYs. The host first sets the transfer direction in a local control register. It then makes one write to a trigger address, and that address alone names the target PHY, page and register. In write mode the data of that trigger write goes to the selected PHY register. In read mode the trigger starts a PHY read, and the host collects the result from a local data register once the bridge is no longer busy.

On the PHY side there is a simple request/acknowledge master port. A request is held, with its target and data stable, until the PHY side returns a single-cycle acknowledge. Malformed triggers never reach the PHY side. They raise an error flag instead. Triggers that arrive while a transfer is in flight are dropped.

Top module: `phy_ind_bridge`

## Requirements
- R1: After reset, busy and error read 0, the direction bit reads 0 (write mode), the data register reads 0xFFFF and no PHY request is raised.
- R2: The direction register is at 0x8000 and only bit 0 is used: 1 selects read, 0 selects write. A host read of it returns the stored bit in bit 0 and zeros elsewhere.
- R3: A host write to an address with bit 15 set, exactly one bit set in bits 13:9 (bit 9+n selects PHY n, n = 0..4), bit 14 clear and a page value in bits 8:5 of at most 7 is a valid trigger. The resulting request carries the one-hot PHY select, the page from bits 8:5 and the register number from bits 4:0.
- R4: In write mode, a valid trigger forwards its write data to the selected PHY register as a write request.
- R5: In read mode, a valid trigger issues a read request. The PHY read data present on the acknowledge cycle is stored in the data register at 0x8002.
- R6: The data register changes only when a read completes. Write transfers, invalid triggers and host writes to 0x8002 leave it unchanged, so it reads 0xFFFF until the first read completes.
- R7: A trigger with bit 15 set that fails R3 (no PHY bit, more than one PHY bit, bit 14 set, or page above 7) causes no PHY request and sets the error flag. The next accepted valid trigger clears the flag.
- R8: Busy, and the PHY request with it, rises on the clock edge that accepts a valid trigger. It stays high until the edge at which the acknowledge is sampled and falls on that edge. The number of busy cycles therefore equals the acknowledge latency.
- R9: A trigger of any kind that arrives while busy is ignored. It does not start a request, does not alter the request in flight and does not change the error flag.
- R10: The status register at 0x8001 returns busy in bit 0 and error in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Host access strobe, one cycle per access |
| host_we_i | input | 1 | Host access is a write |
| host_addr_i | input | 16 | Host register address |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data, valid the cycle after a read strobe |
| busy_o | output | 1 | PHY transfer in flight |
| err_o | output | 1 | Last trigger was malformed |
| phy_req_o | output | 1 | PHY request, held until acknowledge |
| phy_we_o | output | 1 | PHY request is a write |
| phy_sel_o | output | 5 | One-hot PHY select |
| phy_page_o | output | 4 | PHY page |
| phy_reg_o | output | 5 | PHY register number |
| phy_wdata_o | output | 16 | PHY write data |
| phy_ack_i | input | 1 | PHY acknowledge, single cycle |
| phy_rdata_i | input | 16 | PHY read data, valid with acknowledge |

## Verification
A wrongly latched target or direction shows up on the PHY port in the first cycle after the trigger. Either the wrong register of the PHY model changes, or the wrong value reaches 0x8002 as soon as busy falls. A stuck or early-released busy flag shows within the acknowledge latency, because either a second trigger sneaks through or the busy cycle count no longer matches that latency. A data register that updates on the wrong event is seen on the next read of 0x8002, which still has to return 0xFFFF after write transfers.

// File: rtl/phy_bridge_pkg.sv
package phy_bridge_pkg;
  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_LOCAL,
    ACC_TRIG_OK,
    ACC_TRIG_BAD
  } acc_kind_e;

  localparam logic [1:0] LOC_DIR    = 2'd0;
  localparam logic [1:0] LOC_STATUS = 2'd1;
  localparam logic [1:0] LOC_DATA   = 2'd2;
endpackage

// File: rtl/pib_addr_decode.sv
module pib_addr_decode
  import phy_bridge_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_PHY  = 5,
  parameter int REG_W    = 5,
  parameter int PAGE_W   = 4,
  parameter int PAGE_MAX = 7
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output acc_kind_e          kind_o,
  output logic [1:0]         loc_idx_o,
  output logic [NUM_PHY-1:0] sel_o,
  output logic [PAGE_W-1:0]  page_o,
  output logic [REG_W-1:0]   reg_o
);
  localparam int PHY_LSB = REG_W + PAGE_W;
  localparam int SPARE_W = ADDR_W - 1 - PHY_LSB - NUM_PHY;

  logic spare_zero;
  logic marker;

  generate
    if (SPARE_W > 0) begin : g_spare
      assign spare_zero = (addr_i[ADDR_W-2 -: SPARE_W] == '0);
    end else begin : g_nospare
      assign spare_zero = 1'b1;
    end
  endgenerate

  assign marker    = addr_i[ADDR_W-1];
  assign sel_o     = addr_i[PHY_LSB +: NUM_PHY];
  assign page_o    = addr_i[REG_W +: PAGE_W];
  assign reg_o     = addr_i[REG_W-1:0];
  assign loc_idx_o = addr_i[1:0];

  always_comb begin
    kind_o = ACC_NONE;
    if (marker) begin
      if (spare_zero && sel_o == '0 && page_o == '0 && reg_o < REG_W'(3))
        kind_o = ACC_LOCAL;
      else if (spare_zero && $countones(sel_o) == 1 && page_o <= PAGE_W'(PAGE_MAX))
        kind_o = ACC_TRIG_OK;
      else
        kind_o = ACC_TRIG_BAD;
    end
  end
endmodule

// File: rtl/pib_req_engine.sv
module pib_req_engine #(
  parameter int DATA_W  = 16,
  parameter int NUM_PHY = 5,
  parameter int REG_W   = 5,
  parameter int PAGE_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               we_i,
  input  logic [NUM_PHY-1:0] sel_i,
  input  logic [PAGE_W-1:0]  page_i,
  input  logic [REG_W-1:0]   reg_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               phy_ack_i,
  output logic               busy_o,
  output logic               phy_we_o,
  output logic [NUM_PHY-1:0] phy_sel_o,
  output logic [PAGE_W-1:0]  phy_page_o,
  output logic [REG_W-1:0]   phy_reg_o,
  output logic [DATA_W-1:0]  phy_wdata_o,
  output logic               rd_done_o
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      phy_we_o    <= 1'b0;
      phy_sel_o   <= '0;
      phy_page_o  <= '0;
      phy_reg_o   <= '0;
      phy_wdata_o <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q      <= 1'b1;
        phy_we_o    <= we_i;
        phy_sel_o   <= sel_i;
        phy_page_o  <= page_i;
        phy_reg_o   <= reg_i;
        phy_wdata_o <= we_i ? wdata_i : '0;
      end
    end else if (phy_ack_i) begin
      busy_q <= 1'b0;
    end
  end

  assign busy_o    = busy_q;
  assign rd_done_o = busy_q & phy_ack_i & ~phy_we_o;
endmodule

// File: rtl/phy_ind_bridge.sv
module phy_ind_bridge
  import phy_bridge_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int NUM_PHY  = 5,
  parameter int REG_W    = 5,
  parameter int PAGE_W   = 4,
  parameter int PAGE_MAX = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_req_i,
  input  logic               host_we_i,
  input  logic [ADDR_W-1:0]  host_addr_i,
  input  logic [DATA_W-1:0]  host_wdata_i,
  output logic [DATA_W-1:0]  host_rdata_o,
  output logic               busy_o,
  output logic               err_o,
  output logic               phy_req_o,
  output logic               phy_we_o,
  output logic [NUM_PHY-1:0] phy_sel_o,
  output logic [PAGE_W-1:0]  phy_page_o,
  output logic [REG_W-1:0]   phy_reg_o,
  output logic [DATA_W-1:0]  phy_wdata_o,
  input  logic               phy_ack_i,
  input  logic [DATA_W-1:0]  phy_rdata_i
);
  acc_kind_e          kind;
  logic [1:0]         loc_idx;
  logic [NUM_PHY-1:0] dec_sel;
  logic [PAGE_W-1:0]  dec_page;
  logic [REG_W-1:0]   dec_reg;
  logic               host_wr, host_rd, start, rd_done, busy;
  logic               dir_q, err_q;
  logic [DATA_W-1:0]  data_q;

  pib_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_PHY(NUM_PHY), .REG_W(REG_W),
    .PAGE_W(PAGE_W), .PAGE_MAX(PAGE_MAX)
  ) u_dec (
    .addr_i(host_addr_i), .kind_o(kind), .loc_idx_o(loc_idx),
    .sel_o(dec_sel), .page_o(dec_page), .reg_o(dec_reg)
  );

  assign host_wr = host_req_i & host_we_i;
  assign host_rd = host_req_i & ~host_we_i;
  assign start   = host_wr & (kind == ACC_TRIG_OK);

  pib_req_engine #(
    .DATA_W(DATA_W), .NUM_PHY(NUM_PHY), .REG_W(REG_W), .PAGE_W(PAGE_W)
  ) u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .we_i(~dir_q),
    .sel_i(dec_sel), .page_i(dec_page), .reg_i(dec_reg), .wdata_i(host_wdata_i),
    .phy_ack_i(phy_ack_i), .busy_o(busy), .phy_we_o(phy_we_o),
    .phy_sel_o(phy_sel_o), .phy_page_o(phy_page_o), .phy_reg_o(phy_reg_o),
    .phy_wdata_o(phy_wdata_o), .rd_done_o(rd_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= 1'b0;
      err_q  <= 1'b0;
      data_q <= '1;
    end else begin
      if (host_wr && kind == ACC_LOCAL && loc_idx == LOC_DIR)
        dir_q <= host_wdata_i[0];
      if (host_wr && !busy) begin
        if (kind == ACC_TRIG_OK)       err_q <= 1'b0;
        else if (kind == ACC_TRIG_BAD) err_q <= 1'b1;
      end
      if (rd_done)
        data_q <= phy_rdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_rdata_o <= '0;
    end else if (host_rd) begin
      host_rdata_o <= '0;
      if (kind == ACC_LOCAL) begin
        case (loc_idx)
          LOC_DIR:    host_rdata_o <= DATA_W'(dir_q);
          LOC_STATUS: host_rdata_o <= DATA_W'({err_q, busy});
          LOC_DATA:   host_rdata_o <= data_q;
          default:    host_rdata_o <= '0;
        endcase
      end
    end
  end

  assign busy_o    = busy;
  assign phy_req_o = busy;
  assign err_o     = err_q;
endmodule

// File: rtl/pib_checker.sv
module pib_checker #(
  parameter int DATA_W   = 16,
  parameter int NUM_PHY  = 5,
  parameter int REG_W    = 5,
  parameter int PAGE_W   = 4,
  parameter int PAGE_MAX = 7
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               busy_o,
  input logic               err_o,
  input logic               phy_req_o,
  input logic               phy_ack_i,
  input logic               phy_we_o,
  input logic [NUM_PHY-1:0] phy_sel_o,
  input logic [PAGE_W-1:0]  phy_page_o,
  input logic [REG_W-1:0]   phy_reg_o,
  input logic [DATA_W-1:0]  phy_wdata_o,
  input logic [DATA_W-1:0]  data_q
);
  a_r8_release_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && phy_ack_i |=> !busy_o);

  a_r3_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o |-> $countones(phy_sel_o) == 1);

  a_r3_page_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o |-> phy_page_o <= PAGE_W'(PAGE_MAX));

  a_r9_fields_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(phy_sel_o) && $stable(phy_page_o)
      && $stable(phy_reg_o) && $stable(phy_we_o) && $stable(phy_wdata_o));

  a_r6_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && phy_ack_i && !phy_we_o) |=> $stable(data_q));

  a_r7_err_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !busy_o);
endmodule

bind phy_ind_bridge pib_checker #(
  .DATA_W(DATA_W), .NUM_PHY(NUM_PHY), .REG_W(REG_W),
  .PAGE_W(PAGE_W), .PAGE_MAX(PAGE_MAX)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .err_o(err_o),
  .phy_req_o(phy_req_o), .phy_ack_i(phy_ack_i), .phy_we_o(phy_we_o),
  .phy_sel_o(phy_sel_o), .phy_page_o(phy_page_o), .phy_reg_o(phy_reg_o),
  .phy_wdata_o(phy_wdata_o), .data_q(data_q)
);

// File: tb/sim_phy_ind_bridge.sv
`timescale 1ns/1ps
module sim_phy_ind_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [15:0] host_addr = '0, host_wdata = '0;
  logic [15:0] host_rdata;
  logic        busy, err, phy_req, phy_we;
  logic [4:0]  phy_sel;
  logic [3:0]  phy_page;
  logic [4:0]  phy_reg;
  logic [15:0] phy_wdata;
  logic        phy_ack = 1'b0;
  logic [15:0] phy_rdata = '0;

  int checks = 0, failures = 0;
  int lat = 2;
  int acc_cnt = 0;
  int busy_cycles = 0;
  bit done = 0;
  logic [15:0] mem [0:4][0:7][0:31];

  always #10 clk = ~clk;

  phy_ind_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n), .host_req_i(host_req), .host_we_i(host_we),
    .host_addr_i(host_addr), .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .busy_o(busy), .err_o(err), .phy_req_o(phy_req), .phy_we_o(phy_we),
    .phy_sel_o(phy_sel), .phy_page_o(phy_page), .phy_reg_o(phy_reg),
    .phy_wdata_o(phy_wdata), .phy_ack_i(phy_ack), .phy_rdata_i(phy_rdata)
  );

  function automatic logic [15:0] pat(int p, int g, int r);
    return 16'((p << 12) | (g << 8) | r);
  endfunction

  function automatic logic [15:0] trig(int p, int g, int r);
    return 16'h8000 | 16'(1 << (9 + p)) | 16'(g << 5) | 16'(r);
  endfunction

  // PHY register file model, driven on falling edges
  initial begin
    int cnt = 0;
    int pn;
    for (int p = 0; p < 5; p++)
      for (int g = 0; g < 8; g++)
        for (int r = 0; r < 32; r++) mem[p][g][r] = pat(p, g, r);
    forever begin
      @(negedge clk);
      if (phy_ack) begin
        phy_ack = 1'b0;
        cnt = 0;
      end else if (phy_req) begin
        if (cnt == 0) acc_cnt++;
        busy_cycles++;
        cnt++;
        if (cnt >= lat) begin
          pn = 0;
          for (int i = 0; i < 5; i++) if (phy_sel[i]) pn = i;
          if (phy_we) mem[pn][phy_page[2:0]][phy_reg] = phy_wdata;
          phy_rdata = mem[pn][phy_page[2:0]][phy_reg];
          phy_ack = 1'b1;
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_wr(logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk);
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_rd(logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = host_rdata;
    host_req = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 busy", busy, 0);
    chk("R1 err", err, 0);
    chk("R1 req", phy_req, 0);
    host_rd(16'h8000, d); chk("R1 dir", d, 0);
    host_rd(16'h8002, d); chk("R1 data", d, 16'hFFFF);
  endtask

  task automatic t_write_mode();
    logic [15:0] d;
    int a0, b0;
    lat = 3; a0 = acc_cnt; b0 = busy_cycles;
    host_wr(trig(2, 3, 5), 16'hA5A5);
    chk("R8 busy after trigger", busy, 1);
    chk("R3 sel", phy_sel, 5'b00100);
    chk("R3 page", phy_page, 3);
    chk("R3 reg", phy_reg, 5);
    chk("R4 we", phy_we, 1);
    host_rd(16'h8001, d); chk("R10 status busy", d, 16'h0001);
    wait_idle();
    chk("R8 busy cycles", busy_cycles - b0, 3);
    chk("R4 phy written", mem[2][3][5], 16'hA5A5);
    chk("R4 one access", acc_cnt - a0, 1);
    host_wr(16'h8002, 16'h1234);
    host_rd(16'h8002, d); chk("R6 data after write", d, 16'hFFFF);
  endtask

  task automatic t_read_mode();
    logic [15:0] d;
    lat = 1;
    host_wr(16'h8000, 16'hFFFF);
    host_rd(16'h8000, d); chk("R2 dir read", d, 16'h0001);
    host_wr(trig(2, 3, 5), 16'h0000);
    chk("R2 request is read", phy_we, 0);
    wait_idle();
    host_rd(16'h8002, d); chk("R5 read result", d, 16'hA5A5);
    chk("R5 phy not overwritten", mem[2][3][5], 16'hA5A5);
    host_wr(trig(4, 7, 31), 16'h0);
    wait_idle();
    host_rd(16'h8002, d); chk("R5 edge phy4 pg7 reg31", d, pat(4, 7, 31));
    host_wr(trig(0, 0, 0), 16'h0);
    wait_idle();
    host_rd(16'h8002, d); chk("R5 phy0 pg0 reg0", d, pat(0, 0, 0));
  endtask

  task automatic t_invalid();
    logic [15:0] d;
    int a0;
    a0 = acc_cnt;
    host_wr(16'h8003, 16'h0);
    chk("R7 no sel busy", busy, 0);
    chk("R7 no sel err", err, 1);
    host_wr(trig(1, 0, 0) | trig(3, 0, 0), 16'h0);
    chk("R7 two sel err", err, 1);
    host_wr(trig(1, 0, 0) | 16'h4000, 16'h0);
    chk("R7 bit14 err", err, 1);
    host_wr(16'h8000 | 16'(1 << 10) | 16'(8 << 5) | 16'd2, 16'h0);
    chk("R7 page8 busy", busy, 0);
    host_rd(16'h8001, d); chk("R10 status err", d, 16'h0002);
    chk("R7 no access", acc_cnt - a0, 0);
    host_rd(16'h8002, d); chk("R6 data after invalid", d, pat(0, 0, 0));
    host_wr(trig(1, 1, 1), 16'h0);
    chk("R7 err cleared", err, 0);
    wait_idle();
  endtask

  task automatic t_busy_ignore();
    int a0;
    lat = 8;
    host_wr(16'h8000, 16'h0000);
    a0 = acc_cnt;
    host_wr(trig(1, 0, 2), 16'h1111);
    host_wr(trig(3, 0, 4), 16'h2222);
    chk("R9 target held", phy_sel, 5'b00010);
    chk("R9 data held", phy_wdata, 16'h1111);
    host_wr(16'h8003, 16'h0);
    chk("R9 bad ignored", err, 0);
    wait_idle();
    chk("R9 first done", mem[1][0][2], 16'h1111);
    chk("R9 second dropped", mem[3][0][4], pat(3, 0, 4));
    chk("R9 one access", acc_cnt - a0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_mode();
    t_read_mode();
    t_invalid();
    t_busy_ignore();
    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule